// File: doc/BRIEF.md
# Single-Slave Two-Wire Byte Bus Master

This block is the master end of a push/pull two-wire serial link that serves exactly one slave device. Each transaction moves one data byte to or from one register of the slave. Because only one slave exists, the frame carries no slave address. Every byte on the wire is followed by a parity bit and never by an acknowledge. A read takes a single frame: the master sends the register address and a direction bit, then releases the data line and receives the byte straight away.

Software programs the target register address, the direction and, for writes, the data byte through a small word-wide register port. It then sets the start bit. The start bit reads back as a busy flag until the stop condition completes. Completion, parity failure on a read, and an attempt to start while busy each raise a sticky status flag. Each flag has its own enable. The enabled flags are combined with a global enable to form one interrupt line.

Top module: `twb_master`

## Requirements
- R1: After reset, both serial lines are high with the data line driven, the control register (index 0) reads 0, the status register (index 4) reads 0, the divider register (index 6) reads CLK_HZ/(2*100000) (500 at defaults), and irq is low. Whenever no transfer runs, both lines stay high.
- R2: A frame opens with a start condition, which is the data line falling while the clock is high. It then carries 19 bits, MSB first: the 8-bit register address (index 2), its parity bit, a direction bit (1 = read), the 8 data bits, and their parity bit. A stop condition follows. Apart from start and stop, the data line changes only while the clock is low. No other line activity occurs.
- R3: Every parity bit is even parity: it equals the XOR of the 8 bits it follows.
- R4: A read is selected by bit 0 of the mode register (index 1). In a read, the master stops driving the data line (sda_oe low) for the 9 bits after the direction bit and samples them. It stores the received byte into the data register (index 3). A received parity bit that does not match sets the transfer-error flag (status bit 1), and the received byte is still stored.
- R5: Writing 1 to bit 0 of the control register while idle launches a frame. Bit 0 of the control register reads 1 from that write until the stop condition has finished, and 0 afterwards. Bit 1 of the control register is the global interrupt enable.
- R6: Writing 1 to control bit 0 while a frame is in flight sets the load-while-busy flag (status bit 0) and starts no further frame. Register writes made during a frame do not alter the frame in flight.
- R7: The transfer-complete flag (status bit 2) is set at the end of every frame. Each status flag stays set until software writes 1 to its bit of the status register. Writing 0 to a bit leaves that flag unchanged.
- R8: irq is high exactly when the global enable is set and at least one status flag is set whose matching bit in the interrupt-enable register (index 5, same bit positions) is set.
- R9: The divider register gives the number of module clocks in each half bit period, so the clock-high time and the clock-low time of a data bit each last that many module clocks. A value written below ceil(CLK_HZ/(2*6 MHz)) (9 at defaults) is stored as that minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the register selected by reg_addr |
| scl_o | output | 1 | Serial clock line, always driven |
| sda_o | output | 1 | Serial data value driven by the master |
| sda_oe | output | 1 | High when the master drives the data line |
| sda_i | input | 1 | Serial data line as seen at the pin |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a start request that lands while a frame is already on the wire. To reach it, the stimulus launches a frame, waits a fixed number of clocks, and rewrites the start bit, the address and the direction. The bus monitor then confirms that exactly the original frame appears and that no second frame follows. The second is a received parity bit that disagrees with its byte, which only a misbehaving slave can produce. The bench's slave model answers reads from the bus lines and flips its parity bit on request, so the error flag can be checked together with the stored byte.

// File: rtl/twb_pkg.sv
// Package: shared constants and helpers for the two-wire byte bus master.
// Assumes a 3-bit register index and a 16-bit register word.
package twb_pkg;

    localparam int REG_W      = 16;
    localparam int FRAME_BITS = 19;   // addr(8) + par + dir + data(8) + par
    localparam int RX_BITS    = 9;    // data(8) + par on a read

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_MODE  = 3'd1;
    localparam logic [2:0] RA_RADR  = 3'd2;
    localparam logic [2:0] RA_DATA  = 3'd3;
    localparam logic [2:0] RA_STAT  = 3'd4;
    localparam logic [2:0] RA_INTEN = 3'd5;
    localparam logic [2:0] RA_DIV   = 3'd6;

    // Status flag bit positions
    localparam int SF_LOADBUSY = 0;
    localparam int SF_ERR      = 1;
    localparam int SF_DONE     = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_LO,
        PH_HI,
        PH_STOP_LO,
        PH_STOP_HI,
        PH_STOP_END
    } phase_t;

    // Even parity bit over one byte
    function automatic logic even_par(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/twb_halftick.sv
// Module: half-bit period timer.
// Counts module clocks while run is high and pulses tick on the last clock
// of each half period. Assumes div >= 1 (the register file clamps it).
module twb_halftick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div - 1'b1);

    // Count clocks within a half period, restarting at each tick or when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/twb_frame.sv
// Module: frame sequencer for one byte-data transaction.
// Captures the address, direction, write byte and divider on go, then
// sequences start, 19 bit slots, and stop. It samples the slave's bits at
// the end of each clock-high half. Assumes go is raised only while idle.
module twb_frame
    import twb_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DIV_W-1:0] div,
    input  logic [7:0]       addr_byte,
    input  logic [7:0]       wr_byte,
    input  logic             rd_mode,
    input  logic             sda_i,
    output logic             scl_o,
    output logic             sda_o,
    output logic             sda_oe,
    output logic             busy,
    output logic             done,
    output logic             was_read,
    output logic [7:0]       rx_byte,
    output logic             rx_perr
);

    localparam logic [4:0] LAST_IDX = 5'(FRAME_BITS - 1);
    localparam logic [4:0] RX_FIRST = 5'(FRAME_BITS - RX_BITS);

    phase_t                  phase;
    logic [4:0]              idx;
    logic [FRAME_BITS-1:0]   tx;
    logic [RX_BITS-1:0]      rx_sh;
    logic [DIV_W-1:0]        div_l;
    logic                    rdl;
    logic                    tick;
    logic                    in_bit;
    logic                    rx_slot;

    twb_halftick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (phase != PH_IDLE),
        .div  (div_l),
        .tick (tick)
    );

    assign in_bit  = (phase == PH_LO) || (phase == PH_HI);
    assign rx_slot = rdl && (idx >= RX_FIRST);

    // Advance the frame phase and bit index, and shift in received bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            idx   <= '0;
            tx    <= '0;
            rx_sh <= '0;
            div_l <= '0;
            rdl   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase <= PH_START;
                        idx   <= '0;
                        rdl   <= rd_mode;
                        div_l <= div;
                        tx    <= {addr_byte, even_par(addr_byte), rd_mode,
                                  wr_byte, even_par(wr_byte)};
                    end
                end
                PH_START: if (tick) phase <= PH_LO;
                PH_LO:    if (tick) phase <= PH_HI;
                PH_HI: begin
                    if (tick) begin
                        if (rx_slot) rx_sh <= {rx_sh[RX_BITS-2:0], sda_i};
                        if (idx == LAST_IDX) begin
                            phase <= PH_STOP_LO;
                        end else begin
                            idx   <= idx + 1'b1;
                            phase <= PH_LO;
                        end
                    end
                end
                PH_STOP_LO: if (tick) phase <= PH_STOP_HI;
                PH_STOP_HI: if (tick) phase <= PH_STOP_END;
                PH_STOP_END: begin
                    if (tick) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Derive the line levels from the registered phase and bit index
    always_comb begin
        scl_o  = 1'b1;
        sda_o  = 1'b1;
        sda_oe = 1'b1;
        unique case (phase)
            PH_IDLE:     begin scl_o = 1'b1; sda_o = 1'b1; end
            PH_START:    begin scl_o = 1'b1; sda_o = 1'b0; end
            PH_LO, PH_HI: begin
                scl_o = (phase == PH_HI);
                if (rx_slot) begin
                    sda_o  = 1'b1;
                    sda_oe = 1'b0;
                end else begin
                    sda_o = tx[LAST_IDX - idx];
                end
            end
            PH_STOP_LO:  begin scl_o = 1'b0; sda_o = 1'b0; end
            PH_STOP_HI:  begin scl_o = 1'b1; sda_o = 1'b0; end
            PH_STOP_END: begin scl_o = 1'b1; sda_o = 1'b1; end
            default:     begin scl_o = 1'b1; sda_o = 1'b1; end
        endcase
    end

    assign busy     = in_bit || (phase != PH_IDLE);
    assign was_read = rdl;
    assign rx_byte  = rx_sh[RX_BITS-1:1];
    assign rx_perr  = rdl && (rx_sh[0] != even_par(rx_sh[RX_BITS-1:1]));

endmodule

// File: rtl/twb_regs.sv
// Module: software-visible register file.
// Holds control, mode, address, data, status, enable and divider state, and
// turns start-bit writes into a launch pulse or a load-while-busy flag.
// Assumes register writes are single-cycle strobes; reads are combinational.
module twb_regs
    import twb_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int DIV_RST = 500,
    parameter int DIV_MIN = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             busy,
    input  logic             done,
    input  logic             was_read,
    input  logic [7:0]       rx_byte,
    input  logic             rx_perr,
    output logic             go,
    output logic             gie,
    output logic             rd_mode,
    output logic [7:0]       addr_byte,
    output logic [7:0]       data_byte,
    output logic [DIV_W-1:0] div,
    output logic [2:0]       stat,
    output logic [2:0]       inten
);

    logic       ctrl_wr;
    logic       lb_set;
    logic [2:0] stat_set;
    logic [2:0] stat_clr;

    assign ctrl_wr = reg_we && (reg_addr == RA_CTRL);
    assign go      = ctrl_wr && reg_wdata[0] && !busy;
    assign lb_set  = ctrl_wr && reg_wdata[0] && busy;

    always_comb begin
        stat_set              = '0;
        stat_set[SF_LOADBUSY] = lb_set;
        stat_set[SF_ERR]      = done && rx_perr;
        stat_set[SF_DONE]     = done;
        stat_clr = (reg_we && (reg_addr == RA_STAT)) ? reg_wdata[2:0] : 3'b000;
    end

    // Update configuration registers from software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie       <= 1'b0;
            rd_mode   <= 1'b0;
            addr_byte <= '0;
            inten     <= '0;
            div       <= DIV_W'(DIV_RST);
        end else if (reg_we) begin
            unique case (reg_addr)
                RA_CTRL:  gie       <= reg_wdata[1];
                RA_MODE:  rd_mode   <= reg_wdata[0];
                RA_RADR:  addr_byte <= reg_wdata[7:0];
                RA_INTEN: inten     <= reg_wdata[2:0];
                RA_DIV:   div <= (reg_wdata[DIV_W-1:0] < DIV_W'(DIV_MIN)) ?
                                 DIV_W'(DIV_MIN) : reg_wdata[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    // Data register: received byte has priority over a software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_byte <= '0;
        end else if (done && was_read) begin
            data_byte <= rx_byte;
        end else if (reg_we && (reg_addr == RA_DATA)) begin
            data_byte <= reg_wdata[7:0];
        end
    end

    // Sticky status flags: hardware set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            stat <= (stat & ~stat_clr) | stat_set;
        end
    end

    // Select the register word addressed by reg_addr
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL:  reg_rdata = REG_W'({gie, busy});
            RA_MODE:  reg_rdata = REG_W'(rd_mode);
            RA_RADR:  reg_rdata = REG_W'(addr_byte);
            RA_DATA:  reg_rdata = REG_W'(data_byte);
            RA_STAT:  reg_rdata = REG_W'(stat);
            RA_INTEN: reg_rdata = REG_W'(inten);
            RA_DIV:   reg_rdata = REG_W'(div);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/twb_master.sv
// Module: top of the single-slave two-wire byte bus master.
// Joins the register file and the frame sequencer and forms the interrupt.
// Assumes sda_i reflects the pin, including the master's own drive.
module twb_master
    import twb_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int BUS_HZ     = 100_000,
    parameter int MAX_BUS_HZ = 6_000_000,
    parameter int DIV_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             scl_o,
    output logic             sda_o,
    output logic             sda_oe,
    input  logic             sda_i,
    output logic             irq
);

    localparam int DIV_RST = CLK_HZ / (2 * BUS_HZ);
    localparam int DIV_MIN = (CLK_HZ + 2 * MAX_BUS_HZ - 1) / (2 * MAX_BUS_HZ);

    logic             go;
    logic             gie;
    logic             rd_mode;
    logic [7:0]       addr_byte;
    logic [7:0]       data_byte;
    logic [DIV_W-1:0] div;
    logic [2:0]       stat;
    logic [2:0]       inten;
    logic             busy;
    logic             done;
    logic             was_read;
    logic [7:0]       rx_byte;
    logic             rx_perr;

    twb_regs #(
        .DIV_W  (DIV_W),
        .DIV_RST(DIV_RST),
        .DIV_MIN(DIV_MIN)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy     (busy),
        .done     (done),
        .was_read (was_read),
        .rx_byte  (rx_byte),
        .rx_perr  (rx_perr),
        .go       (go),
        .gie      (gie),
        .rd_mode  (rd_mode),
        .addr_byte(addr_byte),
        .data_byte(data_byte),
        .div      (div),
        .stat     (stat),
        .inten    (inten)
    );

    twb_frame #(.DIV_W(DIV_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .div      (div),
        .addr_byte(addr_byte),
        .wr_byte  (data_byte),
        .rd_mode  (rd_mode),
        .sda_i    (sda_i),
        .scl_o    (scl_o),
        .sda_o    (sda_o),
        .sda_oe   (sda_oe),
        .busy     (busy),
        .done     (done),
        .was_read (was_read),
        .rx_byte  (rx_byte),
        .rx_perr  (rx_perr)
    );

    assign irq = gie && (|(stat & inten));

endmodule

// File: rtl/twb_master_chk.sv
// Module: property checker for twb_master, attached by bind.
// Observes ports and the register/sequencer handshake signals.
module twb_master_chk #(
    parameter int DIV_W   = 16,
    parameter int DIV_MIN = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [2:0]       reg_addr,
    input logic [15:0]      reg_wdata,
    input logic             scl_o,
    input logic             sda_o,
    input logic             sda_oe,
    input logic             irq,
    input logic             busy,
    input logic             gie,
    input logic [2:0]       stat,
    input logic [DIV_W-1:0] div
);

    // R1
    idle_lines_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && sda_o && sda_oe));

    // R2
    fall_on_high_only_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && sda_oe && $fell(sda_o)) |-> !$past(busy));

    // R4
    release_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_oe |-> busy);

    // R6
    start_while_busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0 && reg_wdata[0] && busy) |=> stat[0]);

    // R7
    done_flag_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> stat[2]);

    // R8
    irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && stat != 3'b000));

    // R9
    div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div >= DIV_W'(DIV_MIN));

endmodule

bind twb_master twb_master_chk #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .scl_o    (scl_o),
    .sda_o    (sda_o),
    .sda_oe   (sda_oe),
    .irq      (irq),
    .busy     (busy),
    .gie      (gie),
    .stat     (stat),
    .div      (div)
);

// File: tb/twb_master_bench.sv
// Bench: scoreboard for twb_master. The driver pushes expected frames into a
// queue; a bus monitor with a built-in slave model decodes frames and pops.
module twb_master_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        scl_o, sda_o, sda_oe, irq;
    logic        slv_sda = 1'b1;
    logic        sda_bus;
    logic [8:0]  rsp_bits = 9'h1FF;
    logic        gie_b = 1'b0;
    logic [18:0] exp_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          frames_seen = 0;
    int          frames_exp = 0;
    bit          ended = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = sda_oe ? sda_o : slv_sda;

    twb_master u_twb_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .scl_o    (scl_o),
        .sda_o    (sda_o),
        .sda_oe   (sda_oe),
        .sda_i    (sda_bus),
        .irq      (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        do rd(3'd0, v); while (v[0]);
    endtask

    // Driver: program one transaction and push the frame expected on the wire
    task automatic launch(input bit is_rd, input logic [7:0] a, input logic [7:0] d,
                          input logic [7:0] rsp, input bit bad_par);
        rsp_bits = {rsp, (^rsp) ^ bad_par};
        if (is_rd) exp_q.push_back({a, ^a, 1'b1, rsp, (^rsp) ^ bad_par});
        else       exp_q.push_back({a, ^a, 1'b0, d, ^d});
        frames_exp++;
        wr(3'd2, {8'h00, a});
        wr(3'd3, {8'h00, d});
        wr(3'd1, {15'd0, is_rd});
        wr(3'd0, {14'd0, gie_b, 1'b1});
    endtask

    // Monitor and slave: decode each frame from the lines, answer reads
    initial begin : mon
        logic [18:0] fr;
        logic [18:0] ex;
        logic        rdir;
        forever begin
            @(negedge sda_bus iff scl_o);
            fr = '0;
            rdir = 1'b0;
            for (int i = 0; i < 19; i++) begin
                @(posedge scl_o);
                fr = {fr[17:0], sda_bus};
                if (i == 9) rdir = fr[0];
                if (rdir && i >= 9 && i < 18) begin
                    @(negedge scl_o);
                    slv_sda = rsp_bits[17 - i];
                end
            end
            @(negedge scl_o);
            slv_sda = 1'b1;
            frames_seen++;
            if (exp_q.size() == 0) begin
                chk("R6 unexpected frame", {13'd0, fr}, 32'hFFFF_FFFF);
            end else begin
                ex = exp_q.pop_front();
                chk("R2/R3 frame bits", {13'd0, fr}, {13'd0, ex});
            end
        end
    end

    // Measure clock-high and clock-low time of a data bit in module clocks
    task automatic measure(input int exp_div);
        int n;
        @(posedge scl_o);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (scl_o);
        chk("R9 clock high half", n, exp_div);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!scl_o);
        chk("R9 clock low half", n, exp_div);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin : main
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk("R1 control after reset", v, 16'h0000);
        rd(3'd4, v); chk("R1 status after reset", v, 16'h0000);
        rd(3'd6, v); chk("R1 divider default", v, 16'd500);
        chk("R1 idle lines", {irq, scl_o, sda_o, sda_oe}, 4'b0111);

        // R9 divider floor and programming
        wr(3'd6, 16'd2);  rd(3'd6, v); chk("R9 divider clamp", v, 16'd9);
        wr(3'd6, 16'd12); rd(3'd6, v); chk("R9 divider set", v, 16'd12);

        // R2 R3 write frame with timing measurement
        fork
            launch(1'b0, 8'hA5, 8'h3C, 8'h00, 1'b0);
            measure(12);
        join
        wait_idle();
        rd(3'd4, v); chk("R7 done after write", v, 16'h0004);
        wr(3'd4, 16'h0004);
        rd(3'd4, v); chk("R7 clear done", v, 16'h0000);

        // R4 read with good parity
        launch(1'b1, 8'h12, 8'h00, 8'hB7, 1'b0);
        wait_idle();
        rd(3'd3, v); chk("R4 read data stored", v, 16'h00B7);
        rd(3'd4, v); chk("R4 no error on good parity", v, 16'h0004);
        wr(3'd4, 16'h0007);

        // R4 R3 read with corrupted parity
        launch(1'b1, 8'h7E, 8'h00, 8'h01, 1'b1);
        wait_idle();
        rd(3'd3, v); chk("R4 data stored despite parity error", v, 16'h0001);
        rd(3'd4, v); chk("R4 parity error flagged", v, 16'h0006);
        wr(3'd4, 16'h0002);
        rd(3'd4, v); chk("R7 clear error only", v, 16'h0004);
        wr(3'd4, 16'h0000);
        rd(3'd4, v); chk("R7 writing zero keeps flag", v, 16'h0004);
        wr(3'd4, 16'h0004);

        // R5 R6 busy indication and start while busy
        launch(1'b0, 8'h0F, 8'hF0, 8'h00, 1'b0);
        repeat (20) @(negedge clk);
        rd(3'd0, v); chk("R5 busy during frame", {15'd0, v[0]}, 16'h0001);
        wr(3'd0, 16'h0001);
        wr(3'd2, 16'h0055);
        wr(3'd1, 16'h0001);
        wait_idle();
        rd(3'd0, v); chk("R5 busy cleared after frame", {15'd0, v[0]}, 16'h0000);
        rd(3'd4, v); chk("R6 load-while-busy flag", v, 16'h0005);
        repeat (100) @(negedge clk);
        chk("R6 single frame only", frames_seen, frames_exp);

        // R8 interrupt combination, status = load-busy + done
        wr(3'd5, 16'h0004); wr(3'd0, 16'h0002);
        #1 chk("R8 irq done enabled", irq, 1'b1);
        wr(3'd5, 16'h0002);
        #1 chk("R8 irq unmatched enable", irq, 1'b0);
        wr(3'd5, 16'h0001);
        #1 chk("R8 irq load-busy enabled", irq, 1'b1);
        wr(3'd0, 16'h0000);
        #1 chk("R8 irq global disable", irq, 1'b0);
        wr(3'd4, 16'h0007);

        chk("R2 all frames observed", exp_q.size(), 0);
        chk("R1 lines idle at end", {scl_o, sda_o, sda_oe}, 3'b111);
        finish_run();
    end

endmodule